// File: doc/BRIEF.md
# ADC Conversion Sweep Scheduler

This block sits in front of a four-channel pipelined analog-to-digital converter and decides when each channel's conversion goes into the pipeline. Software writes one control byte. The byte holds an enable, one request bit per channel, an abort (flush) strobe and a two-bit field that picks which channels share a merged DMA request. Requested channels are launched one per cycle, lowest channel number first. Each request bit clears as soon as its conversion enters the pipeline.

The converter itself is stood in for by a fixed-latency shift pipeline that returns a done strobe tagged with the channel number. Each completion raises a one-cycle DMA request on that channel's line. It also raises the merged request when the channel falls inside the selected group. A flush throws away everything inside the pipeline, but it leaves the request bits that have not yet launched. After a short restart gap, launching picks up from where it stopped.

Top module: `adc_sweep_sched`

## Requirements
- R1: After a synchronous reset, the read-back value is 0, `launch_valid` is low, and no DMA request is asserted.
- R2: The control byte layout is as follows. Bit 0 is enable and bit 1 is flush. Bits 5:2 are request bits for channels 0 to 3, with channel 0 at bit 2. Bits 7:6 are the group field. A read returns the enable, the pending request bits and the group field, and bit 1 reads as 0.
- R3: A write ORs its request bits into the pending set. Writing a 0 to a request bit never cancels a pending request.
- R4: Pending channels launch at most one per cycle, lowest number first. The first launch is visible the cycle after the write edge, so a four-channel sweep occupies four consecutive cycles.
- R5: A request bit clears on the same edge that launches its conversion, not when the conversion completes.
- R6: While enable is 0, nothing is launched and pending request bits are kept. They launch once enable is written to 1.
- R7: A conversion completes 4 cycles after its launch. One cycle later, exactly one per-channel DMA line pulses high for one cycle.
- R8: A write with the flush bit set does three things. It discards every conversion in the pipeline, so they give no DMA request. It blocks any launch on that edge and on the next edge. Pending requests then resume launching in lowest-first order.
- R9: The merged DMA request pulses together with a per-channel request only when that channel is inside the group. Group 00 means never. Group 01 covers channels 0 and 1, group 10 covers channels 0 to 2, and group 11 covers channels 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Control byte read-back |
| launch_valid | output | 1 | A conversion is launched into the pipeline this cycle |
| launch_ch | output | 2 | Channel of the launched conversion |
| ch_dma_req | output | 4 | Per-channel DMA request pulses |
| grp_dma_req | output | 1 | Merged DMA request pulse for the selected group |

## Verification
On every cycle, the assertions check four things. A launch needs enable and a pending bit on that channel. No lower-numbered channel may be pending at a launch. No launch may follow a flush restart cycle. Per-channel DMA requests are one-hot at most, and the merged request never appears alone. Other properties only show up in the bench's scenarios: the exact order and count of a sweep, the 4-cycle result latency, and the exact set of channels that produce DMA after a flush. The same holds for pending requests surviving a disabled period and the group membership of each encoding.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  localparam int unsigned GRP_W = 2;

  // Group g (non-zero) covers channels 0..g
  function automatic logic grp_hit(input logic [GRP_W-1:0] grp, input int unsigned ch);
    return (grp != '0) && (ch <= 32'(grp));
  endfunction
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl #(
  parameter int unsigned NCH = 4,
  localparam int unsigned DW = NCH + 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic           fire,
  input  logic [NCH-1:0] pick_oh,
  output logic           flush_now,
  output logic           en_q,
  output logic           flush_q,
  output logic [NCH-1:0] pend_q,
  output logic [1:0]     grp_q
);
  logic [NCH-1:0] set_bits;
  logic [NCH-1:0] clr_bits;

  assign flush_now = wr_en && wr_data[1];
  assign set_bits  = wr_en ? wr_data[NCH+1:2] : '0;
  assign clr_bits  = fire ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      flush_q <= 1'b0;
      pend_q  <= '0;
      grp_q   <= '0;
    end else begin
      flush_q <= flush_now;
      pend_q  <= (pend_q & ~clr_bits) | set_bits;
      if (wr_en) begin
        en_q  <= wr_data[0];
        grp_q <= wr_data[DW-1 -: 2];
      end
    end
  end
endmodule

// File: rtl/sched_issue.sv
module sched_issue #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_q,
  input  logic           flush_now,
  input  logic           flush_q,
  input  logic [NCH-1:0] pend_q,
  output logic           fire,
  output logic [NCH-1:0] pick_oh,
  output logic           launch_valid,
  output logic [CHW-1:0] launch_ch
);
  logic [CHW-1:0] pick_idx;

  // Lowest-numbered pending channel wins
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_oh  = NCH'(1) << i;
        pick_idx = CHW'(i);
      end
    end
  end

  assign fire = en_q && (pend_q != '0) && !flush_now && !flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      launch_valid <= 1'b0;
      launch_ch    <= '0;
    end else begin
      launch_valid <= fire;
      if (fire) launch_ch <= pick_idx;
    end
  end
endmodule

// File: rtl/conv_pipe.sv
module conv_pipe #(
  parameter int unsigned LAT = 4,
  parameter int unsigned CHW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush_now,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_ch,
  output logic           done_valid,
  output logic [CHW-1:0] done_ch
);
  logic [LAT-1:0] stg_v;
  logic [CHW-1:0] stg_c [LAT];

  always_ff @(posedge clk) begin
    if (rst || flush_now) begin
      stg_v <= '0;
    end else begin
      stg_v[0] <= in_valid;
      for (int k = 1; k < LAT; k++) stg_v[k] <= stg_v[k-1];
    end
  end

  always_ff @(posedge clk) begin
    stg_c[0] <= in_ch;
    for (int k = 1; k < LAT; k++) stg_c[k] <= stg_c[k-1];
  end

  assign done_valid = stg_v[LAT-1];
  assign done_ch    = stg_c[LAT-1];
endmodule

// File: rtl/dma_merge.sv
module dma_merge #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     grp_q,
  input  logic           done_valid,
  input  logic [CHW-1:0] done_ch,
  output logic [NCH-1:0] ch_dma_req,
  output logic           grp_dma_req
);
  import adc_sched_pkg::*;

  logic [NCH-1:0] member;

  for (genvar g = 0; g < NCH; g++) begin : g_member
    assign member[g] = grp_hit(grp_q, g);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_dma_req  <= '0;
      grp_dma_req <= 1'b0;
    end else begin
      ch_dma_req  <= done_valid ? (NCH'(1) << done_ch) : '0;
      grp_dma_req <= done_valid && member[done_ch];
    end
  end
endmodule

// File: rtl/adc_sweep_sched.sv
module adc_sweep_sched #(
  parameter int unsigned NCH = 4,
  parameter int unsigned LAT = 4,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned DW  = NCH + 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  output logic           launch_valid,
  output logic [CHW-1:0] launch_ch,
  output logic [NCH-1:0] ch_dma_req,
  output logic           grp_dma_req
);
  logic           flush_now;
  logic           en_q;
  logic           flush_q;
  logic [NCH-1:0] pend_q;
  logic [1:0]     grp_q;
  logic           fire;
  logic [NCH-1:0] pick_oh;
  logic           done_valid;
  logic [CHW-1:0] done_ch;

  sched_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fire(fire), .pick_oh(pick_oh), .flush_now(flush_now),
    .en_q(en_q), .flush_q(flush_q), .pend_q(pend_q), .grp_q(grp_q)
  );

  sched_issue #(.NCH(NCH)) u_issue (
    .clk(clk), .rst(rst), .en_q(en_q), .flush_now(flush_now),
    .flush_q(flush_q), .pend_q(pend_q), .fire(fire), .pick_oh(pick_oh),
    .launch_valid(launch_valid), .launch_ch(launch_ch)
  );

  conv_pipe #(.LAT(LAT), .CHW(CHW)) u_pipe (
    .clk(clk), .rst(rst), .flush_now(flush_now),
    .in_valid(launch_valid), .in_ch(launch_ch),
    .done_valid(done_valid), .done_ch(done_ch)
  );

  dma_merge #(.NCH(NCH)) u_dma (
    .clk(clk), .rst(rst), .grp_q(grp_q),
    .done_valid(done_valid), .done_ch(done_ch),
    .ch_dma_req(ch_dma_req), .grp_dma_req(grp_dma_req)
  );

  assign rd_data = {grp_q, pend_q, 1'b0, en_q};
endmodule

// File: rtl/adc_sweep_sched_chk.sv
module adc_sweep_sched_chk #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic           en_q,
  input logic           flush_q,
  input logic [NCH-1:0] pend_q,
  input logic           launch_valid,
  input logic [CHW-1:0] launch_ch,
  input logic           done_valid,
  input logic [NCH-1:0] ch_dma_req,
  input logic           grp_dma_req
);
  // R6
  launch_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> $past(en_q));

  // R8
  flush_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flush_q) |-> !launch_valid);

  // R4
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> (($past(pend_q) & ((NCH'(1) << launch_ch) - NCH'(1))) == '0));

  // R5
  launch_was_pending_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> ($past(pend_q) & (NCH'(1) << launch_ch)) != '0);

  // R7
  dma_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_dma_req));

  // R7
  dma_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $past(done_valid) |-> (ch_dma_req != '0));

  // R9
  grp_with_ch_chk: assert property (@(posedge clk) disable iff (rst)
    grp_dma_req |-> (ch_dma_req != '0));
endmodule

bind adc_sweep_sched adc_sweep_sched_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .flush_q(flush_q), .pend_q(pend_q),
  .launch_valid(launch_valid), .launch_ch(launch_ch), .done_valid(done_valid),
  .ch_dma_req(ch_dma_req), .grp_dma_req(grp_dma_req)
);

// File: tb/adc_sweep_sched_tb.sv
module adc_sweep_sched_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       launch_valid;
  logic [1:0] launch_ch;
  logic [3:0] ch_dma_req;
  logic       grp_dma_req;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  adc_sweep_sched u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .launch_valid(launch_valid), .launch_ch(launch_ch),
    .ch_dma_req(ch_dma_req), .grp_dma_req(grp_dma_req)
  );

  // {write byte, expected DMA channel mask, merged pulse count, first channel}
  localparam logic [15:0] VEC [5] = '{16'h1550, 16'h7DF8, 16'hA9A5, 16'hF1CA, 16'hE187};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic watch(input int n, output logic [3:0] mask, output int grp,
                       output int nl, output int first, output int first_idx,
                       output bit ordered, output int pulses);
    int last;
    mask = 4'h0; grp = 0; nl = 0; first = -1; first_idx = -1;
    ordered = 1'b1; pulses = 0; last = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (launch_valid) begin
        if (nl == 0) begin first = int'(launch_ch); first_idx = i; end
        if (int'(launch_ch) <= last) ordered = 1'b0;
        last = int'(launch_ch);
        nl++;
      end
      mask |= ch_dma_req;
      pulses += $countones(ch_dma_req);
      grp += int'(grp_dma_req);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R4 actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [3:0] mask;
    int grp, nl, first, fidx, pulses;
    bit ordered;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 8'h00, "R1 readback", rd_data, 0);
    chk(!launch_valid && ch_dma_req == 4'h0 && !grp_dma_req, "R1 outputs idle",
        {launch_valid, ch_dma_req, grp_dma_req}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R6 disabled: requests pend, nothing launches
    wr(8'h3C);
    watch(8, mask, grp, nl, first, fidx, ordered, pulses);
    chk(nl == 0, "R6 no launch while disabled", nl, 0);
    chk(rd_data == 8'h3C, "R6 pending kept, R2 layout", rd_data, 8'h3C);

    // R3 a write with zero request bits keeps pending; R5 clear at launch
    wr(8'h01);
    chk(rd_data == 8'h3D && !launch_valid, "R3 pending survives write", rd_data, 8'h3D);
    @(negedge clk);
    chk(launch_valid && launch_ch == 2'd0, "R4 first launch next cycle", launch_ch, 0);
    chk(rd_data == 8'h39, "R5 bit cleared at launch", rd_data, 8'h39);
    watch(12, mask, grp, nl, first, fidx, ordered, pulses);
    chk(nl == 3 && ordered && first == 1, "R6 sweep resumes once enabled", nl, 3);
    chk(rd_data == 8'h01, "R5 all bits cleared", rd_data, 8'h01);

    // Vector table: sweeps with each group encoding
    foreach (VEC[v]) begin
      wr(VEC[v][15:8]);
      watch(14, mask, grp, nl, first, fidx, ordered, pulses);
      chk(first == int'(VEC[v][1:0]) && fidx == 0, "R4 lowest channel first", first, VEC[v][1:0]);
      chk(ordered && nl == $countones(VEC[v][7:4]), "R4 ascending single launches", nl,
          $countones(VEC[v][7:4]));
      chk(mask == VEC[v][7:4], "R7 DMA channel set", mask, VEC[v][7:4]);
      chk(pulses == $countones(VEC[v][7:4]), "R7 one pulse per result", pulses,
          $countones(VEC[v][7:4]));
      chk(grp == int'(VEC[v][3:2]), "R9 merged request count", grp, VEC[v][3:2]);
    end

    // R7 latency: launch then result DMA five cycles after launch visibility
    wr(8'h05);
    @(negedge clk);
    chk(launch_valid && launch_ch == 2'd0, "R7 launch seen", launch_ch, 0);
    repeat (4) @(negedge clk);
    chk(ch_dma_req == 4'h0, "R7 no DMA before latency", ch_dma_req, 0);
    @(negedge clk);
    chk(ch_dma_req == 4'h1, "R7 DMA after latency", ch_dma_req, 1);
    @(negedge clk);
    chk(ch_dma_req == 4'h0, "R7 DMA single cycle", ch_dma_req, 0);
    repeat (4) @(negedge clk);

    // R8 flush after two launches of a four-channel sweep
    wr(8'h3D);
    @(negedge clk);
    chk(launch_valid && launch_ch == 2'd0, "R8 pre-flush launch ch0", launch_ch, 0);
    @(negedge clk);
    chk(launch_valid && launch_ch == 2'd1, "R8 pre-flush launch ch1", launch_ch, 1);
    wr(8'h03);
    chk(!launch_valid, "R8 no launch on flush edge", launch_valid, 0);
    chk(rd_data == 8'h31, "R2 flush reads zero, pending kept", rd_data, 8'h31);
    watch(14, mask, grp, nl, first, fidx, ordered, pulses);
    chk(fidx == 1 && first == 2, "R8 restart gap then ch2", fidx, 1);
    chk(nl == 2 && ordered, "R8 remaining sweep launched", nl, 2);
    chk(mask == 4'hC && pulses == 2, "R8 aborted results dropped", mask, 4'hC);
    chk(grp == 0, "R9 group 00 gives no merged request", grp, 0);

    report();
    $finish;
  end
endmodule